// File: doc/BRIEF.md
# Accumulator Processor with Multi-Cycle Instruction Sequencing

This block is a small accumulator machine. It steps each instruction through a sequence of register transfers, one transfer per clock. The program counter is copied into a memory address register, the word at that address is read into a memory data register, and that word is then moved into an instruction register. The instruction register splits the word into an opcode and an operand, and the control logic acts on them. Instructions and data share a single synchronous single-port memory. That memory sits outside the block and is driven through an address, a write-data bus, a read strobe and a write strobe.

Values enter through a valid/ready input port. The processor raises `in_ready` only while it is executing an input instruction, and it waits there for as long as `in_valid` stays low. That is the only back-pressure the block has. The output port has no ready: `out_valid` is a one-cycle strobe and the consumer must take `out_data` in that cycle. A halt instruction stops the sequencer until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and on its release, the program counter, accumulator and both flags are 0, `halted`, `in_ready` and `out_valid` are low, and the first memory read is at address 0.
- R2: An instruction word is 16 bits, with the opcode in bits 15:12 and the operand address in bits 11:0. The fetch drives the program counter onto `mem_addr` with `mem_re` high. The memory returns the word on `mem_rdata` in the following cycle.
- R3: The program counter advances by exactly 1 per fetch. Without a taken branch, instructions are read from consecutive addresses, and each fetch, operand read and store is one single-cycle memory access.
- R4: Input (opcode 0x9) holds `in_ready` high and stalls until `in_valid` is high. On that handshake it loads `in_data` into the accumulator.
- R5: Output (opcode 0xA) raises `out_valid` for exactly one cycle, with the accumulator value on `out_data`.
- R6: Load (opcode 0x5) reads the word at the operand address into the accumulator and leaves both flags unchanged.
- R7: Store (opcode 0x3) writes the accumulator to the operand address with one single-cycle `mem_we` pulse.
- R8: Add (opcode 0x1) and subtract (opcode 0x2) replace the accumulator with the accumulator plus or minus the word at the operand address, modulo 2^16.
- R9: `flag_zero` (result is all zeros) and `flag_ovf` (two's-complement signed overflow) are written only by add and subtract. Every other instruction leaves them as they were.
- R10: Branch (0x6) always loads the operand into the program counter. Branch-if-zero (0x7) does so only when the accumulator is 0. Branch-if-positive (0x8) does so only when accumulator bit 15 is 0, which includes zero.
- R11: Halt (0x0), and every unassigned opcode (0x4, 0xB to 0xF), raises `halted`. After that there is no memory access and no output strobe until reset.
- R12: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_re | output | 1 | Memory read strobe, data returned next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (memory data register) |
| mem_rdata | input | 16 | Memory read data |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 16 | Input word |
| in_ready | output | 1 | Processor is waiting in an input instruction |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 16 | Output word (accumulator) |
| halted | output | 1 | Processor has stopped |
| flag_zero | output | 1 | Zero flag from the last add or subtract |
| flag_ovf | output | 1 | Signed overflow flag from the last add or subtract |

## Verification
Assertions check the following on every cycle:
- the fetch presents the program counter as the read address, and the counter then steps by one;
- read and write strobes never coincide, and a store writes the accumulator;
- an input handshake loads the input word;
- `out_valid` never lasts two cycles, and a load leaves the flags alone;
- once `halted` is high it stays high, with no memory traffic.

The arithmetic results, the overflow and zero flags, the taken and untaken branch paths, the treatment of unassigned opcodes and the input stall can only be shown by the bench. It runs short programs over a grid of boundary operand values and compares the results with sums computed in the bench.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    OP_HLT = 4'h0,
    OP_ADD = 4'h1,
    OP_SUB = 4'h2,
    OP_STA = 4'h3,
    OP_LDA = 4'h5,
    OP_BRA = 4'h6,
    OP_BRZ = 4'h7,
    OP_BRP = 4'h8,
    OP_INP = 4'h9,
    OP_OUT = 4'hA
  } op_e;

  typedef enum logic [3:0] {
    ST_FADDR,   // PC -> MAR
    ST_FREAD,   // read strobe, PC + 1
    ST_FCAP,    // memory -> MDR
    ST_DECODE,  // MDR -> CIR
    ST_EXEC,    // act on opcode
    ST_MACC,    // operand read or store write
    ST_MCAP,    // memory -> MDR
    ST_WBACK,   // MDR / ALU -> ACC
    ST_HALT
  } state_e;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int WORD_W = OP_W + ADDR_W
) (
  input  logic [WORD_W-1:0] word,
  output op_e               op,
  output logic [ADDR_W-1:0] operand
);
  assign operand = word[ADDR_W-1:0];

  // unassigned codes fall back to halt
  always_comb begin
    case (word[WORD_W-1:ADDR_W])
      4'h1:    op = OP_ADD;
      4'h2:    op = OP_SUB;
      4'h3:    op = OP_STA;
      4'h5:    op = OP_LDA;
      4'h6:    op = OP_BRA;
      4'h7:    op = OP_BRZ;
      4'h8:    op = OP_BRP;
      4'h9:    op = OP_INP;
      4'hA:    op = OP_OUT;
      default: op = OP_HLT;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         res_zero,
  output logic         res_ovf,
  output logic         a_zero,
  output logic         a_pos
);
  logic [W-1:0] b_eff;

  assign b_eff    = sub ? ~b : b;
  assign res      = a + b_eff + {{(W-1){1'b0}}, sub};
  assign res_zero = (res == '0);
  // signed overflow: operands of equal sign (after inversion) give a result of the other sign
  assign res_ovf  = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
  assign a_zero   = (a == '0);
  assign a_pos    = ~a[W-1];
endmodule

// File: rtl/acc_fsm.sv
module acc_fsm
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  op_e    op,
  input  logic   in_valid,
  output state_e state
);
  state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_FADDR:  nxt = ST_FREAD;
      ST_FREAD:  nxt = ST_FCAP;
      ST_FCAP:   nxt = ST_DECODE;
      ST_DECODE: nxt = ST_EXEC;
      ST_EXEC: begin
        case (op)
          OP_HLT:                          nxt = ST_HALT;
          OP_INP:                          nxt = in_valid ? ST_FADDR : ST_EXEC;
          OP_ADD, OP_SUB, OP_LDA, OP_STA:  nxt = ST_MACC;
          default:                         nxt = ST_FADDR;
        endcase
      end
      ST_MACC:   nxt = (op == OP_STA) ? ST_FADDR : ST_MCAP;
      ST_MCAP:   nxt = ST_WBACK;
      ST_WBACK:  nxt = ST_FADDR;
      default:   nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FADDR;
    else        state <= nxt;
  end

  a_r11_halt_sticky_state: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> (state == ST_HALT));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              halted,
  output logic              flag_zero,
  output logic              flag_ovf
);
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, cir, acc;
  op_e               op;
  logic [ADDR_W-1:0] operand;
  state_e            state;
  logic [DATA_W-1:0] alu_res;
  logic              alu_zero, alu_ovf, acc_is_zero, acc_is_pos;

  acc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .word(cir), .op(op), .operand(operand)
  );

  acc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .op(op), .in_valid(in_valid), .state(state)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .a(acc), .b(mdr), .sub(op == OP_SUB),
    .res(alu_res), .res_zero(alu_zero), .res_ovf(alu_ovf),
    .a_zero(acc_is_zero), .a_pos(acc_is_pos)
  );

  // register transfers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= '0;
      mar       <= '0;
      mdr       <= '0;
      cir       <= '0;
      acc       <= '0;
      flag_zero <= 1'b0;
      flag_ovf  <= 1'b0;
    end else begin
      case (state)
        ST_FADDR:  mar <= pc;
        ST_FREAD:  pc  <= pc + 1'b1;
        ST_FCAP:   mdr <= mem_rdata;
        ST_DECODE: cir <= mdr;
        ST_EXEC: begin
          case (op)
            OP_ADD, OP_SUB, OP_LDA: mar <= operand;
            OP_STA: begin
              mar <= operand;
              mdr <= acc;
            end
            OP_INP: if (in_valid) acc <= in_data;
            OP_BRA: pc <= operand;
            OP_BRZ: if (acc_is_zero) pc <= operand;
            OP_BRP: if (acc_is_pos) pc <= operand;
            default: ;
          endcase
        end
        ST_MCAP: mdr <= mem_rdata;
        ST_WBACK: begin
          if (op == OP_LDA) begin
            acc <= mdr;
          end else begin
            acc       <= alu_res;
            flag_zero <= alu_zero;
            flag_ovf  <= alu_ovf;
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_re    = (state == ST_FREAD) || ((state == ST_MACC) && (op != OP_STA));
  assign mem_we    = (state == ST_MACC) && (op == OP_STA);
  assign in_ready  = (state == ST_EXEC) && (op == OP_INP);
  assign out_valid = (state == ST_EXEC) && (op == OP_OUT);
  assign out_data  = acc;
  assign halted    = (state == ST_HALT);

  a_r2_fetch_reads_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FADDR) |=> (mem_re && mem_addr == $past(pc)));

  a_r3_pc_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FREAD) |=> (pc == $past(pc) + 1'b1));

  a_r4_input_loads_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (acc == $past(in_data)));

  a_r5_out_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r7_store_writes_acc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc));

  a_r9_load_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WBACK && op == OP_LDA) |=>
      (flag_zero == $past(flag_zero) && flag_ovf == $past(flag_ovf)));

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_re && !mem_we && !out_valid));

  a_r12_no_re_we: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_re, mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, out_valid, halted, flag_zero, flag_ovf;
  logic [15:0] out_data;

  always #4 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .halted(halted),
    .flag_zero(flag_zero), .flag_ovf(flag_ovf)
  );

  logic [15:0] mem [0:255];
  logic [15:0] last_out;
  int n_out, re_cnt, we_cnt, both_cnt;
  logic [11:0] first_re_addr;
  bit first_seen;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr[7:0]] <= mem_wdata; we_cnt <= we_cnt + 1; end
    if (mem_re) begin
      mem_rdata <= mem[mem_addr[7:0]];
      re_cnt <= re_cnt + 1;
      if (!first_seen) begin first_re_addr <= mem_addr; first_seen <= 1'b1; end
    end
    if (mem_re && mem_we) both_cnt <= both_cnt + 1;
    if (out_valid) begin last_out <= out_data; n_out <= n_out + 1; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int adr);
    return 16'((op << 12) | (adr & 12'hFFF));
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic run_prog();
    rst_n = 1'b0;
    @(negedge clk);
    n_out = 0; re_cnt = 0; we_cnt = 0; first_seen = 0; last_out = 'x;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] vals [9] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h1234, 16'hC000, 16'h4000};
    both_cnt = 0;

    // R1: reset state and first fetch address
    clear_mem();
    mem[0] = ins(10, 0); mem[1] = ins(0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    n_out = 0; re_cnt = 0; first_seen = 0;
    chk("R1 halted in reset", halted, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after reset", in_ready, 0);
    chk("R1 zero flag after reset", flag_zero, 0);
    chk("R1 ovf flag after reset", flag_ovf, 0);
    for (int i = 0; i < 50 && !halted; i++) @(negedge clk);
    chk("R1 first read address", first_re_addr, 0);
    chk("R1 acc cleared (OUT value)", last_out, 16'h0000);
    chk("R5 one strobe", n_out, 1);

    // R8/R9/R7/R3: add and subtract sweep
    in_valid = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 9; i++) begin
        for (int j = 0; j < 9; j++) begin
          logic [15:0] a, b, e;
          logic ev;
          a = vals[i]; b = vals[j];
          e  = (s == 0) ? a + b : a - b;
          ev = (s == 0) ? ((a[15] == b[15]) && (e[15] != a[15]))
                        : ((a[15] != b[15]) && (e[15] != a[15]));
          clear_mem();
          mem[0] = ins(9, 0); mem[1] = ins(s == 0 ? 1 : 2, 8); mem[2] = ins(3, 9);
          mem[3] = ins(10, 0); mem[4] = ins(0, 0); mem[8] = b;
          in_data = a;
          run_prog();
          chk("R8 result on output", out_data == e && last_out == e, 1);
          chk("R7 stored word", mem[9], e);
          chk("R7 single write", we_cnt, 1);
          chk("R9 zero flag", flag_zero, e == 16'h0);
          chk("R9 ovf flag", flag_ovf, ev);
          chk("R3 read count", re_cnt, 6);
          chk("R11 halted at end", halted, 1);
        end
      end
    end

    // R10: conditional branches
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 9; i++) begin
        logic [15:0] a;
        bit taken;
        a = vals[i];
        taken = (k == 0) ? (a == 16'h0) : (a[15] == 1'b0);
        clear_mem();
        mem[0] = ins(9, 0); mem[1] = ins(k == 0 ? 7 : 8, 4); mem[2] = ins(5, 10);
        mem[3] = ins(6, 5); mem[4] = ins(5, 11); mem[5] = ins(10, 0); mem[6] = ins(0, 0);
        mem[10] = 16'hAAAA; mem[11] = 16'h5555;
        in_data = a;
        run_prog();
        chk(k == 0 ? "R10 branch-if-zero" : "R10 branch-if-positive",
            last_out, taken ? 16'h5555 : 16'hAAAA);
        chk("R6 load flags untouched", {flag_zero, flag_ovf}, 2'b00);
      end
    end

    // R9/R6: flags survive a later load
    clear_mem();
    mem[0] = ins(9, 0); mem[1] = ins(1, 8); mem[2] = ins(5, 9); mem[3] = ins(10, 0);
    mem[4] = ins(0, 0); mem[8] = 16'h0001; mem[9] = 16'h0005;
    in_data = 16'h7FFF;
    run_prog();
    chk("R6 load value", last_out, 16'h0005);
    chk("R9 ovf kept after load", flag_ovf, 1);
    clear_mem();
    mem[0] = ins(1, 8); mem[1] = ins(5, 9); mem[2] = ins(10, 0); mem[3] = ins(0, 0);
    mem[9] = 16'h0005;
    run_prog();
    chk("R9 zero kept after load", flag_zero, 1);

    // R11: unassigned opcodes halt, nothing further happens
    foreach (vals[q]) begin end
    for (int c = 0; c < 16; c++) begin
      if (c == 4 || c == 0 || c >= 11) begin
        clear_mem();
        mem[0] = ins(c, 0); mem[1] = ins(10, 0);
        run_prog();
        repeat (20) @(negedge clk);
        chk("R11 halted", halted, 1);
        chk("R11 only one read", re_cnt, 1);
        chk("R11 no output", n_out, 0);
      end
    end

    // R4: input stall
    clear_mem();
    mem[0] = ins(9, 0); mem[1] = ins(10, 0); mem[2] = ins(0, 0);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    n_out = 0; re_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R4 waiting ready", in_ready, 1);
    chk("R4 not halted while waiting", halted, 0);
    chk("R4 one fetch while waiting", re_cnt, 1);
    in_data = 16'h3C3C; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 ready drops after handshake", in_ready, 0);
    for (int i = 0; i < 50 && !halted; i++) @(negedge clk);
    chk("R4 value captured", last_out, 16'h3C3C);
    chk("R12 no simultaneous strobes", both_cnt, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule